// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out the stack side of control transfers in a 24-bit-address processor core: subroutine calls of three reach classes, plain and extended returns, the return from an interrupt handler, and the software trap. The decoder hands it one request with an operation code, the PC of the current instruction, that instruction's length in bytes, the branch target operand, the PSW1 byte and the interrupt-mode flag. The block then moves the return address (and PSW1 where the case calls for it) to or from a byte-wide stack memory, one byte per clock. It owns the stack pointer. When the last byte has moved, it presents the new PC with a one-cycle done pulse. When PSW1 was restored, a load strobe accompanies that pulse.

A write first advances the stack pointer and then stores the byte at the new top. A read takes the byte at the top and then retreats the pointer. Multi-byte values go onto the stack low byte first, so they come back high byte first. While a request is in progress, busy stays high and further requests are ignored. The stack memory returns read data in the same cycle that the address is presented.

Top module: `cr_stack_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, busy, done, psw1_load, mem_we and mem_re are 0 and sp_out equals the SP_INIT parameter (default 8'h07).
- R2: Op code 0 (short-reach call): return address = cur_pc + 2; its bits [7:0] then [15:8] are pushed; new PC = return address bits [23:11] joined with target bits [10:0].
- R3: Op code 1 (far call): return address = cur_pc + instr_size; bytes [7:0], [15:8], [23:16] are pushed in that order; new PC = target[23:0].
- R4: Op code 2 (16-bit call): return address = cur_pc + instr_size; bytes [7:0] then [15:8] are pushed; new PC = return address bits [23:16] joined with target bits [15:0].
- R5: Op code 3 (short return): two bytes are popped, the first one giving PC bits [15:8] and the second giving bits [7:0]; PC bits [23:16] are kept from cur_pc.
- R6: Op code 4 (far return): three bytes are popped and become PC bits [23:16], [15:8] and [7:0], in that order.
- R7: Op code 5 (interrupt return): with intr_mode 0 it behaves as R5 and psw1_load stays 0; with intr_mode 1 it pops PC bits [23:16], [15:8], [7:0] and then a fourth byte that appears on psw1_out, with psw1_load high in the done cycle.
- R8: Op code 6 (trap): return address = cur_pc + instr_size; with intr_mode 0 bytes [7:0], [15:8] are pushed; with intr_mode 1 psw1_in is pushed first, then bytes [7:0], [15:8], [23:16]; new PC = TRAP_VEC parameter (default 24'h000100).
- R9: A push drives mem_addr = sp_out + 1 and sp_out increments after it; a pop drives mem_addr = sp_out and sp_out decrements after it; reads and writes never coincide.
- R10: After the request is accepted, one stack byte moves per cycle. Done is a one-cycle pulse in the cycle after the last byte, so it comes N+1 cycles after acceptance for N bytes. Busy is high from acceptance through done, and requests made while busy cause no stack traffic.
- R11: Op code 7 moves no bytes; done follows acceptance by one cycle with new PC = cur_pc and sp_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 3 | Operation code (0..7, see R2 to R11) |
| cur_pc | input | 24 | PC of the current instruction |
| instr_size | input | 3 | Length of the current instruction in bytes |
| target | input | 24 | Branch target operand |
| psw1_in | input | 8 | PSW1 value to save on a mode-1 trap |
| intr_mode | input | 1 | Interrupt-mode flag |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 24 | Resulting PC, valid with done |
| psw1_out | output | 8 | Restored PSW1, valid with psw1_load |
| psw1_load | output | 1 | PSW1 restore strobe, only with done |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | SP_W | Stack byte address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, same-cycle |
| sp_out | output | SP_W | Current stack pointer |

## Verification
On every cycle, the assertions check the pointer discipline: a write goes to the slot above the pointer and is followed by an increment, a read is followed by a decrement, and read and write strobes never overlap. They also check that no stack traffic happens while idle, that done is a single-cycle pulse inside busy, and that the PSW1 strobe comes only with done. The bench scenarios are needed for the byte order of each frame, the reach of each call variant, the mode-dependent frame sizes, the trap vector, and the exact latency. They are also needed to show that a request made while busy changes nothing. Each scenario pairs a push with its matching pop, so a frame laid down by one operation must be read back correctly by the next.

// File: rtl/cr_stack_pkg.sv
package cr_stack_pkg;

  localparam int PC_W    = 24;
  localparam int BYTE_W  = 8;
  localparam int FRAME_B = 4;                 // largest frame in bytes
  localparam int FRAME_W = FRAME_B * BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_B + 1);

  typedef enum logic [2:0] {
    OP_CALL_ABS  = 3'd0,
    OP_CALL_EXT  = 3'd1,
    OP_CALL_LONG = 3'd2,
    OP_RET_SHORT = 3'd3,
    OP_RET_EXT   = 3'd4,
    OP_RET_INT   = 3'd5,
    OP_TRAP      = 3'd6,
    OP_NONE      = 3'd7
  } cr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } cr_state_e;

endpackage

// File: rtl/cr_sp_ctr.sv
module cr_sp_ctr #(
  parameter int          SP_W    = 8,
  parameter int unsigned SP_INIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_d;
  logic            sp_en;

  assign sp_en = inc | dec;
  assign sp_up = sp_q + SP_W'(1);

  always_comb begin
    sp_d = sp_q;
    if (inc)      sp_d = sp_up;
    else if (dec) sp_d = sp_q - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_W'(SP_INIT);
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

endmodule

// File: rtl/cr_req_decode.sv
module cr_req_decode
  import cr_stack_pkg::*;
(
  input  cr_op_e                  op,
  input  logic                    mode,
  input  logic [PC_W-1:0]         cur_pc,
  input  logic [2:0]              instr_size,
  input  logic [BYTE_W-1:0]       psw1_in,
  output logic [CNT_W-1:0]        n_bytes,
  output logic                    is_push,
  output logic [PC_W-1:0]         ret_pc,
  output logic [FRAME_W-1:0]      push_word
);

  // Frame bytes are emitted from push_word[7:0] upward.
  always_comb begin
    if (op == OP_CALL_ABS) ret_pc = cur_pc + PC_W'(2);
    else                   ret_pc = cur_pc + PC_W'(instr_size);

    n_bytes   = '0;
    is_push   = 1'b0;
    push_word = '0;
    unique case (op)
      OP_CALL_ABS, OP_CALL_LONG: begin
        n_bytes   = CNT_W'(2);
        is_push   = 1'b1;
        push_word = {16'h0000, ret_pc[15:0]};
      end
      OP_CALL_EXT: begin
        n_bytes   = CNT_W'(3);
        is_push   = 1'b1;
        push_word = {8'h00, ret_pc};
      end
      OP_RET_SHORT: n_bytes = CNT_W'(2);
      OP_RET_EXT:   n_bytes = CNT_W'(3);
      OP_RET_INT:   n_bytes = mode ? CNT_W'(4) : CNT_W'(2);
      OP_TRAP: begin
        is_push = 1'b1;
        if (mode) begin
          n_bytes   = CNT_W'(4);
          push_word = {ret_pc, psw1_in};
        end else begin
          n_bytes   = CNT_W'(2);
          push_word = {16'h0000, ret_pc[15:0]};
        end
      end
      default: n_bytes = '0;
    endcase
  end

endmodule

// File: rtl/cr_pc_select.sv
module cr_pc_select
  import cr_stack_pkg::*;
#(
  parameter logic [23:0] TRAP_VEC = 24'h000100
) (
  input  cr_op_e              op,
  input  logic                mode,
  input  logic [PC_W-1:0]     ret_pc,
  input  logic [PC_W-1:0]     target,
  input  logic [PC_W-1:0]     base_pc,
  input  logic [FRAME_W-1:0]  pop_acc,
  output logic [PC_W-1:0]     new_pc,
  output logic [BYTE_W-1:0]   psw_val,
  output logic                psw_restore
);

  // pop_acc holds popped bytes, earliest in the highest position used.
  always_comb begin
    psw_val     = pop_acc[7:0];
    psw_restore = 1'b0;
    unique case (op)
      OP_CALL_ABS:  new_pc = {ret_pc[23:11], target[10:0]};
      OP_CALL_EXT:  new_pc = target;
      OP_CALL_LONG: new_pc = {ret_pc[23:16], target[15:0]};
      OP_RET_SHORT: new_pc = {base_pc[23:16], pop_acc[15:0]};
      OP_RET_EXT:   new_pc = pop_acc[23:0];
      OP_RET_INT: begin
        if (mode) begin
          new_pc      = pop_acc[31:8];
          psw_restore = 1'b1;
        end else begin
          new_pc      = {base_pc[23:16], pop_acc[15:0]};
        end
      end
      OP_TRAP:      new_pc = TRAP_VEC;
      default:      new_pc = base_pc;
    endcase
  end

endmodule

// File: rtl/cr_stack_seq.sv
module cr_stack_seq
  import cr_stack_pkg::*;
#(
  parameter int          SP_W     = 8,
  parameter int unsigned SP_INIT  = 7,
  parameter logic [23:0] TRAP_VEC = 24'h000100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [23:0]     cur_pc,
  input  logic [2:0]      instr_size,
  input  logic [23:0]     target,
  input  logic [7:0]      psw1_in,
  input  logic            intr_mode,
  output logic            busy,
  output logic            done,
  output logic [23:0]     new_pc,
  output logic [7:0]      psw1_out,
  output logic            psw1_load,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic [SP_W-1:0] sp_out
);

  cr_state_e          state_q, state_d;
  cr_op_e             op_in, op_q;
  logic               mode_q;
  logic [PC_W-1:0]    ret_q, target_q, base_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   nbytes_q, step_q, step_d;
  logic               push_q;
  logic [FRAME_W-1:0] acc_q, acc_d;

  logic [CNT_W-1:0]   dec_n;
  logic               dec_push;
  logic [PC_W-1:0]    dec_ret;
  logic [FRAME_W-1:0] dec_frame;

  logic               accept, xfer, last_step;
  logic [SP_W-1:0]    sp, sp_up;
  logic [BYTE_W-1:0]  frame_bytes [FRAME_B];
  logic               psw_restore;

  assign op_in = cr_op_e'(req_op);

  cr_req_decode u_decode (
    .op         (op_in),
    .mode       (intr_mode),
    .cur_pc     (cur_pc),
    .instr_size (instr_size),
    .psw1_in    (psw1_in),
    .n_bytes    (dec_n),
    .is_push    (dec_push),
    .ret_pc     (dec_ret),
    .push_word  (dec_frame)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign xfer      = (state_q == ST_XFER);
  assign last_step = (step_q == nbytes_q - CNT_W'(1));

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = (dec_n == '0) ? ST_DONE : ST_XFER;
      ST_XFER: if (last_step) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step_d = step_q;
    if (accept)    step_d = '0;
    else if (xfer) step_d = step_q + CNT_W'(1);
  end

  always_comb begin
    acc_d = acc_q;
    if (accept)      acc_d = '0;
    else if (mem_re) acc_d = {acc_q[FRAME_W-BYTE_W-1:0], mem_rdata};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      mode_q   <= 1'b0;
      ret_q    <= '0;
      target_q <= '0;
      base_q   <= '0;
      frame_q  <= '0;
      nbytes_q <= '0;
      push_q   <= 1'b0;
    end else if (accept) begin
      op_q     <= op_in;
      mode_q   <= intr_mode;
      ret_q    <= dec_ret;
      target_q <= target;
      base_q   <= cur_pc;
      frame_q  <= dec_frame;
      nbytes_q <= dec_n;
      push_q   <= dec_push;
    end
  end

  // frame byte lanes
  for (genvar g = 0; g < FRAME_B; g++) begin : g_lane
    assign frame_bytes[g] = frame_q[g*BYTE_W +: BYTE_W];
  end

  cr_sp_ctr #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (mem_we),
    .dec   (mem_re),
    .sp    (sp),
    .sp_up (sp_up)
  );

  assign mem_we    = xfer &  push_q;
  assign mem_re    = xfer & ~push_q;
  assign mem_addr  = push_q ? sp_up : sp;
  assign mem_wdata = frame_bytes[step_q[$clog2(FRAME_B)-1:0]];
  assign sp_out    = sp;

  cr_pc_select #(.TRAP_VEC(TRAP_VEC)) u_pcsel (
    .op          (op_q),
    .mode        (mode_q),
    .ret_pc      (ret_q),
    .target      (target_q),
    .base_pc     (base_q),
    .pop_acc     (acc_q),
    .new_pc      (new_pc),
    .psw_val     (psw1_out),
    .psw_restore (psw_restore)
  );

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign psw1_load = done & psw_restore;

endmodule

// File: rtl/cr_stack_seq_chk.sv
module cr_stack_seq_chk #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            psw1_load,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr,
  input logic [SP_W-1:0] sp_out
);

  // R9
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R9
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == SP_W'(sp_out + 1'b1));

  // R9
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == SP_W'($past(sp_out) + 1'b1));

  // R9
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr == sp_out);

  // R9
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_out == SP_W'($past(sp_out) - 1'b1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R7
  psw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw1_load |-> done);

endmodule

bind cr_stack_seq cr_stack_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .psw1_load (psw1_load),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .sp_out    (sp_out)
);

// File: tb/cr_stack_seq_bench.sv
module cr_stack_seq_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          SP_W       = 8;
  localparam int unsigned SP_INIT    = 7;
  localparam logic [23:0] TRAP_VEC   = 24'h000100;

  logic            clk, rst_n, req_valid, intr_mode;
  logic [2:0]      req_op, instr_size;
  logic [23:0]     cur_pc, target, new_pc;
  logic [7:0]      psw1_in, psw1_out, mem_wdata, mem_rdata;
  logic            busy, done, psw1_load, mem_we, mem_re;
  logic [SP_W-1:0] mem_addr, sp_out;

  cr_stack_seq #(.SP_W(SP_W), .SP_INIT(SP_INIT), .TRAP_VEC(TRAP_VEC)) u_cr_stack_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .cur_pc(cur_pc), .instr_size(instr_size), .target(target),
    .psw1_in(psw1_in), .intr_mode(intr_mode), .busy(busy), .done(done),
    .new_pc(new_pc), .psw1_out(psw1_out), .psw1_load(psw1_load),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp_out(sp_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stack memory model, same-cycle read
  logic [7:0] ram [256];
  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  int checks = 0;
  int errors = 0;

  // scoreboard queues
  logic [15:0] exp_wr[$];
  string       exp_wr_req[$];
  logic [7:0]  exp_rd[$];
  string       exp_rd_req[$];
  logic [32:0] exp_done[$];
  string       exp_done_req[$];

  logic [7:0] shadow [256];
  int         sp_m;
  int         nbytes;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic exp_push(input logic [7:0] b, input string req);
    sp_m = (sp_m + 1) % 256;
    shadow[sp_m] = b;
    exp_wr.push_back({sp_m[7:0], b});
    exp_wr_req.push_back(req);
    nbytes++;
  endtask

  task automatic exp_pop(output logic [7:0] b, input string req);
    exp_rd.push_back(sp_m[7:0]);
    exp_rd_req.push_back(req);
    b = shadow[sp_m];
    sp_m = (sp_m + 255) % 256;
    nbytes++;
  endtask

  // monitor
  logic [15:0] m_w;
  logic [7:0]  m_r;
  logic [32:0] m_d;
  string       m_q;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_wr.size() == 0) chk(0, "R10", "unexpected push", {mem_addr, mem_wdata}, 0);
        else begin
          m_w = exp_wr.pop_front(); m_q = exp_wr_req.pop_front();
          chk({mem_addr, mem_wdata} == m_w, m_q, "push addr/data", {mem_addr, mem_wdata}, m_w);
        end
      end
      if (mem_re) begin
        if (exp_rd.size() == 0) chk(0, "R10", "unexpected pop", mem_addr, 0);
        else begin
          m_r = exp_rd.pop_front(); m_q = exp_rd_req.pop_front();
          chk(mem_addr == m_r, m_q, "pop addr", mem_addr, m_r);
        end
      end
      if (done) begin
        if (exp_done.size() == 0) chk(0, "R10", "unexpected done", new_pc, 0);
        else begin
          m_d = exp_done.pop_front(); m_q = exp_done_req.pop_front();
          chk({psw1_load, psw1_load ? psw1_out : 8'h00, new_pc} == m_d, m_q,
              "load/psw/pc", {psw1_load, psw1_load ? psw1_out : 8'h00, new_pc}, m_d);
        end
      end
    end
  end

  // driver
  task automatic run_op(input logic [2:0] op, input logic [23:0] pc, input logic [2:0] size,
                        input logic [23:0] tgt, input logic [7:0] psw, input logic mode,
                        input bit poke, input string req);
    logic [23:0] ret, npc;
    logic [7:0]  b0, b1, b2, b3;
    logic        ld;
    int          lat;
    nbytes = 0; ld = 1'b0; npc = pc; b3 = 8'h00;
    ret = (op == 3'd0) ? pc + 24'd2 : pc + 24'(size);
    case (op)
      3'd0: begin exp_push(ret[7:0], req); exp_push(ret[15:8], req); npc = {ret[23:11], tgt[10:0]}; end
      3'd1: begin exp_push(ret[7:0], req); exp_push(ret[15:8], req); exp_push(ret[23:16], req); npc = tgt; end
      3'd2: begin exp_push(ret[7:0], req); exp_push(ret[15:8], req); npc = {ret[23:16], tgt[15:0]}; end
      3'd3: begin exp_pop(b1, req); exp_pop(b0, req); npc = {pc[23:16], b1, b0}; end
      3'd4: begin exp_pop(b2, req); exp_pop(b1, req); exp_pop(b0, req); npc = {b2, b1, b0}; end
      3'd5: begin
        if (mode) begin
          exp_pop(b2, req); exp_pop(b1, req); exp_pop(b0, req); exp_pop(b3, req);
          npc = {b2, b1, b0}; ld = 1'b1;
        end else begin
          exp_pop(b1, req); exp_pop(b0, req); npc = {pc[23:16], b1, b0};
        end
      end
      3'd6: begin
        if (mode) exp_push(psw, req);
        exp_push(ret[7:0], req); exp_push(ret[15:8], req);
        if (mode) exp_push(ret[23:16], req);
        npc = TRAP_VEC;
      end
      default: npc = pc;
    endcase
    exp_done.push_back({ld, ld ? b3 : 8'h00, npc});
    exp_done_req.push_back(req);

    @(negedge clk);
    req_valid = 1'b1; req_op = op; cur_pc = pc; instr_size = size;
    target = tgt; psw1_in = psw; intr_mode = mode;
    @(negedge clk);
    lat = 1;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    if (poke) begin
      // R10: a second request while busy must be ignored
      req_op = 3'd1; cur_pc = 24'h777777; target = 24'h555555; intr_mode = 1'b1;
    end else req_valid = 1'b0;
    while (!done && lat < 20) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end
    chk(lat == nbytes + 1, req, "latency to done (R10)", lat, nbytes + 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10", "idle after done", {busy, done}, 0);
    chk(sp_out == sp_m[SP_W-1:0], "R9", "stack pointer after op", sp_out, sp_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; cur_pc = '0; instr_size = '0;
    target = '0; psw1_in = '0; intr_mode = 1'b0;
    sp_m = int'(SP_INIT);
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk({busy, done, psw1_load, mem_we, mem_re} == 5'b0, "R1", "strobes in reset",
        {busy, done, psw1_load, mem_we, mem_re}, 0);
    chk(sp_out == SP_W'(SP_INIT), "R1", "sp in reset", sp_out, SP_INIT);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, psw1_load, mem_we, mem_re} == 5'b0, "R1", "strobes after reset",
        {busy, done, psw1_load, mem_we, mem_re}, 0);
    chk(sp_out == SP_W'(SP_INIT), "R1", "sp after reset", sp_out, SP_INIT);

    run_op(3'd0, 24'h123456, 3'd2, 24'h0007AB, 8'h00, 1'b0, 0, "R2");
    run_op(3'd3, 24'h12F000, 3'd1, 24'h000000, 8'h00, 1'b0, 0, "R5");
    run_op(3'd0, 24'h0007FF, 3'd2, 24'h000123, 8'h00, 1'b0, 0, "R2");
    run_op(3'd3, 24'h340000, 3'd1, 24'h000000, 8'h00, 1'b0, 0, "R5");
    run_op(3'd1, 24'h00FFFE, 3'd3, 24'hABCDEF, 8'h00, 1'b0, 0, "R3");
    run_op(3'd2, 24'hABCDEF, 3'd3, 24'h001234, 8'h00, 1'b0, 0, "R4");
    run_op(3'd3, 24'hAB1234, 3'd1, 24'h000000, 8'h00, 1'b0, 0, "R5");
    run_op(3'd4, 24'hABCDF2, 3'd1, 24'h000000, 8'h00, 1'b0, 0, "R6");
    run_op(3'd6, 24'h002000, 3'd1, 24'h000000, 8'h3C, 1'b0, 0, "R8");
    run_op(3'd5, 24'h550100, 3'd1, 24'h000000, 8'h00, 1'b0, 0, "R7");
    run_op(3'd6, 24'h345678, 3'd2, 24'h000000, 8'hA5, 1'b1, 1, "R8");
    run_op(3'd5, 24'h000100, 3'd1, 24'h000000, 8'h00, 1'b1, 0, "R7");
    run_op(3'd7, 24'h9ABCDE, 3'd1, 24'h111111, 8'h00, 1'b0, 0, "R11");

    chk(exp_wr.size() == 0 && exp_rd.size() == 0 && exp_done.size() == 0, "R10",
        "scoreboard drained", exp_wr.size() + exp_rd.size() + exp_done.size(), 0);
    finish_run();
  end

endmodule